// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block evaluates eight sum-of-products functions. The connection pattern is held in a configuration store that can be loaded and changed at runtime. Sixteen signals enter the array: eight dedicated inputs and eight feedback inputs. Each signal is expanded into a true line and a complement line, which gives 32 lines. Each of 64 product terms ANDs together the lines whose connection cell is set. Fixed OR gates then combine the terms in groups, one group per output.

Each output owns eight consecutive product-term rows. Seven rows always feed the output's OR. A per-output routing bit decides where the eighth row goes. It either joins the OR as one more term, or it is brought out on its own as an enable term. A surrounding output stage or I/O ring can use that enable term.

The store is written one 32-bit row at a time on a word-wide port. A single-cycle erase strobe opens every connection at once. The logic outputs are combinational, both from the input signals and from the stored map.

Top module: `pla_array`

## Requirements
- R1: Signal s (0..7 taken from `ded_in[s]`, 8..15 taken from `fb_in[s-8]`) drives line 2s with its true value and line 2s+1 with its complement; bit n of a configuration row connects line n.
- R2: Product-term row o*8+k belongs to output o; k = 0..6 are its group terms and k = 7 is its extra term.
- R3: A product term is the AND of every line whose connection bit is 1 in its row.
- R4: A row with no connection bits set evaluates TRUE.
- R5: A row that connects both line 2s and line 2s+1 of any signal evaluates FALSE, whatever the inputs.
- R6: `sum_out[o]` is the OR of output o's seven group terms, together with its extra term when `route_bits[o]` is 0.
- R7: When `route_bits[o]` is 1, the extra term is left out of `sum_out[o]` and appears on `oe_out[o]`; when it is 0, `oe_out[o]` is 1.
- R8: A row write or a routing write changes the outputs only after the next rising clock edge. `cfg_erase` opens all 2048 cells in that one edge and wins over a row write in the same cycle. Erase leaves the routing bits unchanged.
- R9: After a synchronous reset, every cell is open and every routing bit is 0, so all outputs read 1.
- R10: Outputs follow changes on `ded_in` and `fb_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_erase | input | 1 | Bulk erase strobe, opens every connection |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | 6 | Product-term row address |
| cfg_row | input | 32 | Connection bits for the addressed row |
| route_we | input | 1 | Routing bits write enable |
| route_bits | input | 8 | Extra-term routing per output, 1 means enable term |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or I/O input signals |
| sum_out | output | 8 | OR result per output |
| oe_out | output | 8 | Enable term per output |

## Verification
The assertions assume that the configuration strobes and the address are defined, not X, in every cycle after reset, and that nothing writes an address outside 0 to 63. The array treats any mix of input values as legal, so the assertions place no other condition on the data or signal inputs.

The stimulus changes inputs only on the falling edge. It draws addresses from the full 6-bit range, where every address is valid. It builds random rows sparsely, so that product terms evaluate TRUE often enough to be observed.

Directed cases cover each of the following:
- a fully conflicting map
- a single-line connection in each polarity
- a connection to a feedback line
- both routing choices
- an erase and a write issued in the same cycle

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int N_DED  = 8;
    localparam int N_FB   = 8;
    localparam int N_SIG  = N_DED + N_FB;
    localparam int N_LINE = 2 * N_SIG;
    localparam int N_OUT  = 8;
    localparam int GRP    = 7;
    localparam int SLOT   = GRP + 1;
    localparam int N_PT   = N_OUT * SLOT;
    localparam int AW     = $clog2(N_PT);

    typedef logic [N_LINE-1:0] row_t;
    typedef logic [N_SIG-1:0]  sig_t;
    typedef logic [N_PT-1:0]   pt_vec_t;
    typedef logic [N_OUT-1:0]  out_vec_t;

    typedef enum logic {
        ROUTE_SUM = 1'b0,
        ROUTE_OE  = 1'b1
    } route_e;

    typedef struct packed {
        out_vec_t sum;
        out_vec_t oe;
    } pla_res_t;

    // Line 2s is the true value of signal s, line 2s+1 its complement.
    function automatic row_t expand_lines(sig_t s);
        row_t l;
        for (int i = 0; i < N_SIG; i++) begin
            l[2*i]   = s[i];
            l[2*i+1] = ~s[i];
        end
        return l;
    endfunction

    // A term is TRUE unless some connected line is low.
    function automatic logic term_eval(row_t conn, row_t lines);
        return &(lines | ~conn);
    endfunction

    function automatic logic has_conflict(row_t conn);
        logic c;
        c = 1'b0;
        for (int i = 0; i < N_SIG; i++)
            c = c | (conn[2*i] & conn[2*i+1]);
        return c;
    endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  row_t                 wdata,
    input  logic                 route_we,
    input  out_vec_t             route_wdata,
    output row_t [N_PT-1:0]      map,
    output out_vec_t             route
);
    row_t [N_PT-1:0] cells;
    out_vec_t        route_q;

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            cells <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else if (route_we) begin
            route_q <= route_wdata;
        end
    end

    assign map   = cells;
    assign route = route_q;

    // R8: erase opens every cell in one edge
    p_erase_opens_all_r8: assert property (@(posedge clk) disable iff (rst)
        erase |=> (map == '0));

    // R8: a plain write lands on the addressed row
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !erase) |=> (map[$past(addr)] == $past(wdata)));

    // R8: erase leaves the routing bits alone
    p_erase_keeps_route_r8: assert property (@(posedge clk) disable iff (rst)
        (erase && !route_we) |=> $stable(route));

    // R9: reset leaves the array open
    p_reset_open_r9: assert property (@(posedge clk)
        rst |=> (map == '0 && route == '0));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  row_t            lines,
    input  row_t [N_PT-1:0] map,
    output pt_vec_t         pt
);
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pt[t] = term_eval(map[t], lines);

        // R4: an open row is TRUE
        p_open_true_r4: assert property (@(posedge clk) disable iff (rst)
            (map[t] == '0) |-> pt[t]);

        // R5: a row holding both polarities of one signal is FALSE
        p_conflict_false_r5: assert property (@(posedge clk) disable iff (rst)
            has_conflict(map[t]) |-> !pt[t]);
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pt_vec_t  pt,
    input  out_vec_t route,
    output pla_res_t res
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [GRP-1:0] grp;
        logic           extra;
        route_e         sel;

        assign grp   = pt[o*SLOT +: GRP];
        assign extra = pt[o*SLOT + GRP];
        assign sel   = route_e'(route[o]);

        always_comb begin
            res.sum[o] = |grp;
            res.oe[o]  = 1'b1;
            if (sel == ROUTE_SUM) begin
                res.sum[o] = res.sum[o] | extra;
            end else begin
                res.oe[o] = extra;
            end
        end

        // R6: any TRUE group term drives the sum high
        p_group_sets_sum_r6: assert property (@(posedge clk) disable iff (rst)
            (|pt[o*SLOT +: GRP]) |-> res.sum[o]);

        // R7: a routed-away extra term cannot raise the sum
        p_extra_excluded_r7: assert property (@(posedge clk) disable iff (rst)
            (route[o] && (pt[o*SLOT +: GRP] == '0)) |-> !res.sum[o]);

        // R7: enable held high while the extra term feeds the sum
        p_oe_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
            !route[o] |-> res.oe[o]);
    end
endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_erase,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [31:0] cfg_row,
    input  logic        route_we,
    input  logic [7:0]  route_bits,
    input  logic [7:0]  ded_in,
    input  logic [7:0]  fb_in,
    output logic [7:0]  sum_out,
    output logic [7:0]  oe_out
);
    row_t [N_PT-1:0] map;
    out_vec_t        route;
    row_t            lines;
    pt_vec_t         pt;
    pla_res_t        res;

    assign lines = expand_lines({fb_in, ded_in});

    pla_cfg_store u_store (
        .clk         (clk),
        .rst         (rst),
        .erase       (cfg_erase),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_row),
        .route_we    (route_we),
        .route_wdata (route_bits),
        .map         (map),
        .route       (route)
    );

    pla_and_plane u_and (
        .clk   (clk),
        .rst   (rst),
        .lines (lines),
        .map   (map),
        .pt    (pt)
    );

    pla_or_plane u_or (
        .clk   (clk),
        .rst   (rst),
        .pt    (pt),
        .route (route),
        .res   (res)
    );

    assign sum_out = res.sum;
    assign oe_out  = res.oe;

    // R9: right after reset, everything reads 1
    p_reset_all_high_r9: assert property (@(posedge clk)
        rst |=> (sum_out == '1 && oe_out == '1));
endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_erase, cfg_we, route_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_row;
    logic [7:0]  route_bits, ded_in, fb_in;
    logic [7:0]  sum_out, oe_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] ref_map [64];
    logic [7:0]  ref_route;

    always #2 clk = ~clk;

    pla_array u_pla_array (
        .clk(clk), .rst(rst), .cfg_erase(cfg_erase), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_row(cfg_row), .route_we(route_we),
        .route_bits(route_bits), .ded_in(ded_in), .fb_in(fb_in),
        .sum_out(sum_out), .oe_out(oe_out)
    );

    function automatic logic ref_term(logic [31:0] conn, logic [7:0] d, logic [7:0] f);
        logic r;
        r = 1'b1;
        for (int s = 0; s < 16; s++) begin
            logic v;
            v = (s < 8) ? d[s] : f[s-8];
            if (conn[2*s] && !v) r = 1'b0;
            if (conn[2*s+1] && v) r = 1'b0;
        end
        return r;
    endfunction

    task automatic expect_out(string req);
        logic [7:0] es, eo;
        #1;
        for (int o = 0; o < 8; o++) begin
            logic g, x;
            g = 1'b0;
            for (int k = 0; k < 7; k++) g = g | ref_term(ref_map[o*8+k], ded_in, fb_in);
            x = ref_term(ref_map[o*8+7], ded_in, fb_in);
            es[o] = ref_route[o] ? g : (g | x);
            eo[o] = ref_route[o] ? x : 1'b1;
        end
        n_chk++;
        if (sum_out !== es) begin
            n_fail++;
            $display("FAIL %s sum_out actual=%h expected=%h", req, sum_out, es);
        end
        n_chk++;
        if (oe_out !== eo) begin
            n_fail++;
            $display("FAIL %s oe_out actual=%h expected=%h", req, oe_out, eo);
        end
    endtask

    task automatic wr_row(int a, logic [31:0] r);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_row = r;
        @(negedge clk);
        cfg_we = 1'b0;
        ref_map[a] = r;
    endtask

    task automatic wr_route(logic [7:0] m);
        @(negedge clk);
        route_we = 1'b1; route_bits = m;
        @(negedge clk);
        route_we = 1'b0;
        ref_route = m;
    endtask

    task automatic do_erase();
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
        for (int i = 0; i < 64; i++) ref_map[i] = '0;
    endtask

    function automatic logic [31:0] rand_row();
        logic [31:0] r;
        r = '0;
        for (int s = 0; s < 16; s++) begin
            int c;
            c = int'($urandom % 8);
            if (c == 0) r[2*s] = 1'b1;
            else if (c == 1) r[2*s+1] = 1'b1;
        end
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_erase = 0; cfg_we = 0; route_we = 0;
        cfg_addr = 0; cfg_row = 0; route_bits = 0; ded_in = 8'h5a; fb_in = 8'hc3;
        for (int i = 0; i < 64; i++) ref_map[i] = '0;
        ref_route = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R9 reset open");
        ded_in = 8'h00; fb_in = 8'hff;
        expect_out("R9 reset open pattern2");

        // All rows conflicting on signal 0: every term FALSE
        for (int i = 0; i < 64; i++) wr_row(i, 32'h3);
        expect_out("R5 conflict rows");

        // R3/R1: dedicated 0 true line
        wr_row(0, 32'h1);
        ded_in = 8'h01; expect_out("R3 R1 true line high");
        ded_in = 8'h00; expect_out("R3 R1 true line low");
        wr_row(0, 32'h2);
        expect_out("R1 complement line");
        wr_row(0, 32'h3);

        // R2/R1: feedback 0 is line 16, row 9 is output 1 term 1
        wr_row(9, 32'h0001_0000);
        fb_in = 8'h01; expect_out("R2 R1 feedback line");
        fb_in = 8'h00; expect_out("R2 feedback low");

        // R4/R6: open extra row feeds sum of output 0
        wr_row(7, 32'h0);
        expect_out("R4 R6 open extra in sum");
        // R7: route extra term of output 0 away
        wr_route(8'h01);
        expect_out("R7 extra routed to enable");
        wr_row(7, 32'h3);
        expect_out("R7 enable FALSE");

        // R10: combinational response without a clock edge
        wr_row(2, 32'h0000_0400);
        @(negedge clk);
        ded_in = 8'h20; expect_out("R10 comb rise");
        ded_in = 8'h00; expect_out("R10 comb fall");

        // R8: write not visible before the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd16; cfg_row = 32'h0;
        expect_out("R8 before edge");
        @(negedge clk);
        cfg_we = 1'b0; ref_map[16] = 32'h0;
        expect_out("R8 after edge");

        // R8: erase beats same-cycle write, routing kept
        @(negedge clk);
        cfg_erase = 1'b1; cfg_we = 1'b1; cfg_addr = 6'd7; cfg_row = 32'h3;
        @(negedge clk);
        cfg_erase = 1'b0; cfg_we = 1'b0;
        for (int i = 0; i < 64; i++) ref_map[i] = '0;
        expect_out("R8 erase wins");
        wr_row(7, 32'h3);
        expect_out("R8 routing kept after erase");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int act;
            act = int'($urandom % 40);
            if (act == 0) do_erase();
            else if (act < 5) wr_route(8'($urandom));
            else wr_row(int'($urandom % 64), rand_row());
            ded_in = 8'($urandom); fb_in = 8'($urandom);
            expect_out("R3 R6 R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule